// File: doc/BRIEF.md
# Per-CPU Interrupt Interface Arbiter

This block sits between an interrupt distributor and one processor. Each cycle it looks at the sources that the distributor reports as pending for this processor, already enabled and routed, along with the 8-bit priority of each source. It keeps those that are below the programmable priority threshold and can preempt whatever the processor is currently servicing. From these it picks the one with the numerically lowest priority value, and the lowest source number wins a tie. A registered interrupt request line goes high while such a winner exists and the interface is switched on.

Software uses a small four-word register window. One word switches signalling on. One holds the priority threshold. Reading the claim word returns the winner's identifier and makes that source active. Writing a source identifier to the completion word retires it. The block tells the distributor about each claim and each retirement with a one-cycle strobe that carries the identifier, so the distributor can clear or re-arm its pending bit. Two sources can be active at once: the one being serviced, and one that it preempted.

Top module: `cpu_irq_arbiter`

## Requirements
- R1: Bit 0 of the control word (address 0) enables signalling. It resets to 0. While it is 0, `irq_o` stays low and a claim read returns 1023 and changes nothing.
- R2: The threshold word (address 1) holds an 8-bit value in bits [7:0]. It resets to 0 and reads back as written. Only sources whose priority is numerically below it are eligible.
- R3: Among eligible sources, the lowest priority value wins, and equal values go to the lowest source number.
- R4: A claim read (address 2) returns the winner's number in bits [9:0]. The next cycle `act_o` pulses for one cycle with that number on `act_id_o`, and the source is active from then on.
- R5: For a software-generated source (numbers 0 to N_SGI-1), the claim data also carries that source's requesting processor number from `sgi_cpu_i` in bits [12:10]. For any other source those bits are 0.
- R6: If nothing is eligible, a claim read returns 1023 in bits [9:0] with bits [12:10] zero. It gives no `act_o` pulse and leaves the active state alone.
- R7: A write of a source number in bits [9:0] to the completion word (address 3) retires that source if it is active. The next cycle `deact_o` pulses with the number on `deact_id_o`. Retiring the serviced source brings back the one it preempted.
- R8: A completion write whose number is not active is ignored. No `deact_o` pulse follows and no state changes.
- R9: While a source is active, only sources with a strictly lower priority value than the serviced one are eligible. An active source is never eligible. With two sources active, nothing is eligible.
- R10: `irq_o` is registered. It follows eligibility one cycle later, so it falls one cycle after the edge that takes a claim when nothing else is eligible.
- R11: Sources are numbered 0 to N_SRC-1, with N_SRC at most 1020. The values 1020 to 1023 never name a claimed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pend_i | input | N_SRC | Pending, enabled and routed sources from the distributor |
| prio_i | input | N_SRC*8 | Priority of each source, 8 bits per source, source 0 lowest |
| sgi_cpu_i | input | N_SGI*CPU_W | Requesting processor number of each software-generated source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of address 2 is a claim) |
| reg_addr_i | input | 2 | Word address: 0 control, 1 threshold, 2 claim, 3 completion |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Interrupt request to the processor |
| act_o | output | 1 | One-cycle strobe: a source was claimed |
| act_id_o | output | 10 | Number of the claimed source |
| deact_o | output | 1 | One-cycle strobe: a source was retired |
| deact_id_o | output | 10 | Number of the retired source |

## Verification
The hardest state to reach is the full active record. A preempted source and its preemptor are both active, and the completion writes may arrive out of order. Reaching it needs a claim of one priority, then a strictly better source becoming pending and being claimed while the first is still open. The bench gets there both with a directed sequence and with a long pseudo-random run. That run mixes pending patterns with coarse priority steps, so ties and preemption are frequent, together with threshold changes, claims, and completion writes that aim at the serviced source, at the preempted one, or at numbers that are not active.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned MAX_SRC = 1020;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_CLAIM = 2'd2,
    REG_DONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;
endpackage

// File: rtl/cpuif_elig.sv
module cpuif_elig
  import cpuif_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       pmask_i,
  input  logic [PRIO_W:0]         run_lim_i,
  input  logic                    cur_v_i,
  input  logic [ID_W-1:0]         cur_id_i,
  input  logic                    prev_v_i,
  input  logic [ID_W-1:0]         prev_id_i,
  output cand_t [N_SRC-1:0]       cand_o
);
  // Per-source filter: pending, under threshold, able to preempt, not active.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] p;
    logic              busy;
    logic              ok;
    assign p    = prio_i[i*PRIO_W +: PRIO_W];
    assign busy = (cur_v_i  && (cur_id_i  == ID_W'(i))) ||
                  (prev_v_i && (prev_id_i == ID_W'(i)));
    assign ok   = pend_i[i] && (p < pmask_i) && ({1'b0, p} < run_lim_i) && !busy;
    assign cand_o[i] = '{vld: ok, prio: p, id: ID_W'(i)};
  end
endmodule

// File: rtl/cpuif_sel_tree.sv
module cpuif_sel_tree
  import cpuif_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  cand_t [N_SRC-1:0] cand_i,
  output cand_t             best_o
);
  localparam int unsigned LVL = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned P   = 1 << LVL;

  // Heap-ordered tree: leaves at P..2P-1, root at 1.
  cand_t node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N_SRC) begin : g_real
      assign node[P+i] = cand_i[i];
    end else begin : g_pad
      assign node[P+i] = '0;
    end
  end

  // Left child holds lower numbers, so it keeps ties.
  for (genvar k = 1; k < P; k++) begin : g_node
    logic take_left;
    assign take_left = node[2*k].vld &&
                       (!node[2*k+1].vld || (node[2*k].prio <= node[2*k+1].prio));
    assign node[k] = take_left ? node[2*k] : node[2*k+1];
  end

  assign best_o = node[1];
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active
  import cpuif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_fire_i,
  input  cand_t             sel_i,
  input  logic              eoi_fire_i,
  input  logic [ID_W-1:0]   eoi_id_i,
  output logic              cur_v_o,
  output logic [ID_W-1:0]   cur_id_o,
  output logic              prev_v_o,
  output logic [ID_W-1:0]   prev_id_o,
  output logic [PRIO_W:0]   run_lim_o,
  output logic              act_o,
  output logic [ID_W-1:0]   act_id_o,
  output logic              deact_o,
  output logic [ID_W-1:0]   deact_id_o
);
  logic              cur_v_q,  cur_v_d;
  logic [ID_W-1:0]   cur_id_q, cur_id_d;
  logic [PRIO_W-1:0] cur_p_q,  cur_p_d;
  logic              prev_v_q,  prev_v_d;
  logic [ID_W-1:0]   prev_id_q, prev_id_d;
  logic [PRIO_W-1:0] prev_p_q,  prev_p_d;
  logic              act_q, act_d;
  logic [ID_W-1:0]   act_id_q, act_id_d;
  logic              deact_q, deact_d;
  logic [ID_W-1:0]   deact_id_q, deact_id_d;
  logic              slot_en;
  logic              hit_cur, hit_prev;

  assign hit_cur  = cur_v_q  && (eoi_id_i == cur_id_q);
  assign hit_prev = prev_v_q && (eoi_id_i == prev_id_q);
  assign slot_en  = ack_fire_i || eoi_fire_i;

  always_comb begin
    cur_v_d    = cur_v_q;
    cur_id_d   = cur_id_q;
    cur_p_d    = cur_p_q;
    prev_v_d   = prev_v_q;
    prev_id_d  = prev_id_q;
    prev_p_d   = prev_p_q;
    act_d      = 1'b0;
    act_id_d   = act_id_q;
    deact_d    = 1'b0;
    deact_id_d = deact_id_q;
    if (ack_fire_i) begin
      prev_v_d  = cur_v_q;
      prev_id_d = cur_id_q;
      prev_p_d  = cur_p_q;
      cur_v_d   = 1'b1;
      cur_id_d  = sel_i.id;
      cur_p_d   = sel_i.prio;
      act_d     = 1'b1;
      act_id_d  = sel_i.id;
    end else if (eoi_fire_i) begin
      if (hit_cur) begin
        cur_v_d    = prev_v_q;
        cur_id_d   = prev_id_q;
        cur_p_d    = prev_p_q;
        prev_v_d   = 1'b0;
        deact_d    = 1'b1;
        deact_id_d = eoi_id_i;
      end else if (hit_prev) begin
        prev_v_d   = 1'b0;
        deact_d    = 1'b1;
        deact_id_d = eoi_id_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v_q   <= 1'b0;
      cur_id_q  <= '0;
      cur_p_q   <= '0;
      prev_v_q  <= 1'b0;
      prev_id_q <= '0;
      prev_p_q  <= '0;
    end else if (slot_en) begin
      cur_v_q   <= cur_v_d;
      cur_id_q  <= cur_id_d;
      cur_p_q   <= cur_p_d;
      prev_v_q  <= prev_v_d;
      prev_id_q <= prev_id_d;
      prev_p_q  <= prev_p_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      act_id_q   <= '0;
      deact_q    <= 1'b0;
      deact_id_q <= '0;
    end else begin
      act_q      <= act_d;
      act_id_q   <= act_id_d;
      deact_q    <= deact_d;
      deact_id_q <= deact_id_d;
    end
  end

  // Preemption limit: all when idle, strictly better when one open, none when full.
  always_comb begin
    if (!cur_v_q)      run_lim_o = {1'b1, {PRIO_W{1'b0}}};
    else if (prev_v_q) run_lim_o = '0;
    else               run_lim_o = {1'b0, cur_p_q};
  end

  assign cur_v_o    = cur_v_q;
  assign cur_id_o   = cur_id_q;
  assign prev_v_o   = prev_v_q;
  assign prev_id_o  = prev_id_q;
  assign act_o      = act_q;
  assign act_id_o   = act_id_q;
  assign deact_o    = deact_q;
  assign deact_id_o = deact_id_q;

  assert_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v_q |-> (cur_v_q && (cur_p_q < prev_p_q)));
  assert_act_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> $past(ack_fire_i));
  assert_deact_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_q |-> $past(eoi_fire_i));
  assert_distinct_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v_q && prev_v_q) |-> (cur_id_q != prev_id_q));
endmodule

// File: rtl/cpuif_regs.sv
module cpuif_regs
  import cpuif_pkg::*;
#(
  parameter int unsigned N_SGI = 16,
  parameter int unsigned CPU_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  input  cand_t                  sel_i,
  input  logic [N_SGI*CPU_W-1:0] sgi_cpu_i,
  output logic                   en_o,
  output logic [PRIO_W-1:0]      pmask_o,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic                   ack_fire_o,
  output logic                   eoi_fire_o,
  output logic [ID_W-1:0]        eoi_id_o
);
  reg_sel_e          sel_addr;
  logic              en_q, en_d;
  logic [PRIO_W-1:0] pmask_q, pmask_d;
  logic              ctrl_we, pmask_we;
  logic              grant;
  logic [CPU_W-1:0]  ack_cpu;
  logic              unused_wdata;

  assign sel_addr = reg_sel_e'(reg_addr_i);
  assign ctrl_we  = reg_wr_i && (sel_addr == REG_CTRL);
  assign pmask_we = reg_wr_i && (sel_addr == REG_PMASK);
  assign grant    = en_q && sel_i.vld;

  assign ack_fire_o = reg_rd_i && (sel_addr == REG_CLAIM) && grant;
  assign eoi_fire_o = reg_wr_i && (sel_addr == REG_DONE);
  assign eoi_id_o   = reg_wdata_i[ID_W-1:0];
  assign unused_wdata = ^reg_wdata_i[REG_W-1:ID_W];

  always_comb begin
    en_d    = ctrl_we  ? reg_wdata_i[0]        : en_q;
    pmask_d = pmask_we ? reg_wdata_i[PRIO_W-1:0] : pmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pmask_q <= '0;
    end else begin
      en_q    <= en_d;
      pmask_q <= pmask_d;
    end
  end

  // Requesting processor of a software-generated winner.
  always_comb begin
    ack_cpu = '0;
    for (int s = 0; s < N_SGI; s++) begin
      if (sel_i.id == ID_W'(s)) ack_cpu = sgi_cpu_i[s*CPU_W +: CPU_W];
    end
  end

  always_comb begin
    unique case (sel_addr)
      REG_CTRL:  reg_rdata_o = REG_W'(en_q);
      REG_PMASK: reg_rdata_o = REG_W'(pmask_q);
      REG_CLAIM: reg_rdata_o = grant ? REG_W'({ack_cpu, sel_i.id}) : REG_W'(SPURIOUS_ID);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign pmask_o = pmask_q;

  assert_pmask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pmask_we |=> $stable(pmask_q));
endmodule

// File: rtl/cpu_irq_arbiter.sv
module cpu_irq_arbiter
  import cpuif_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_SGI = 16,
  parameter int unsigned CPU_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         pend_i,
  input  logic [N_SRC*PRIO_W-1:0]  prio_i,
  input  logic [N_SGI*CPU_W-1:0]   sgi_cpu_i,
  input  logic                     reg_wr_i,
  input  logic                     reg_rd_i,
  input  logic [1:0]               reg_addr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o,
  output logic                     irq_o,
  output logic                     act_o,
  output logic [ID_W-1:0]          act_id_o,
  output logic                     deact_o,
  output logic [ID_W-1:0]          deact_id_o
);
  if (N_SRC > MAX_SRC || N_SGI > N_SRC) begin : g_bad_cfg
    $error("cpu_irq_arbiter: source count out of range");
  end

  logic              rst_meta_q, rst_sync_q;
  logic              en;
  logic [PRIO_W-1:0] pmask;
  logic [PRIO_W:0]   run_lim;
  logic              cur_v, prev_v;
  logic [ID_W-1:0]   cur_id, prev_id;
  logic              ack_fire, eoi_fire;
  logic [ID_W-1:0]   eoi_id;
  cand_t [N_SRC-1:0] cand;
  cand_t             best;
  logic              irq_q, irq_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cpuif_elig #(.N_SRC(N_SRC)) elig_i (
    .pend_i    (pend_i),
    .prio_i    (prio_i),
    .pmask_i   (pmask),
    .run_lim_i (run_lim),
    .cur_v_i   (cur_v),
    .cur_id_i  (cur_id),
    .prev_v_i  (prev_v),
    .prev_id_i (prev_id),
    .cand_o    (cand)
  );

  cpuif_sel_tree #(.N_SRC(N_SRC)) tree_i (
    .cand_i (cand),
    .best_o (best)
  );

  cpuif_regs #(.N_SGI(N_SGI), .CPU_W(CPU_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .sel_i       (best),
    .sgi_cpu_i   (sgi_cpu_i),
    .en_o        (en),
    .pmask_o     (pmask),
    .reg_rdata_o (reg_rdata_o),
    .ack_fire_o  (ack_fire),
    .eoi_fire_o  (eoi_fire),
    .eoi_id_o    (eoi_id)
  );

  cpuif_active active_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .ack_fire_i (ack_fire),
    .sel_i      (best),
    .eoi_fire_i (eoi_fire),
    .eoi_id_i   (eoi_id),
    .cur_v_o    (cur_v),
    .cur_id_o   (cur_id),
    .prev_v_o   (prev_v),
    .prev_id_o  (prev_id),
    .run_lim_o  (run_lim),
    .act_o      (act_o),
    .act_id_o   (act_id_o),
    .deact_o    (deact_o),
    .deact_id_o (deact_id_o)
  );

  assign irq_d = en && best.vld;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_gated_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_o |-> $past(en));
  assert_act_id_range_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    act_o |-> (act_id_o < ID_W'(N_SRC)));
  assert_spurious_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (reg_rd_i && (reg_addr_i == 2'(REG_CLAIM)) && !(en && best.vld)) |=> !act_o);
endmodule

// File: tb/cpu_irq_arbiter_tb.sv
`timescale 1ns/1ps
module cpu_irq_arbiter_tb_top;
  localparam int NS = 32;
  localparam int NG = 16;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0]   pend_i = '0;
  logic [NS*8-1:0] prio_i = '0;
  logic [NG*CW-1:0] sgi_cpu_i = '0;
  logic          reg_wr_i = 1'b0;
  logic          reg_rd_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_o, act_o, deact_o;
  logic [9:0]    act_id_o, deact_id_o;

  always #2.5 clk = ~clk;

  cpu_irq_arbiter #(.N_SRC(NS), .N_SGI(NG), .CPU_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .prio_i(prio_i), .sgi_cpu_i(sgi_cpu_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .act_o(act_o), .act_id_o(act_id_o), .deact_o(deact_o), .deact_id_o(deact_id_o));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Requirement-level model
  bit         m_pend [NS];
  logic [7:0] m_prio [NS];
  logic [7:0] m_mask = 8'h00;
  bit         m_en = 0;
  bit         mc_v = 0, mp_v = 0;
  int         mc_id = 0, mp_id = 0;
  logic [7:0] mc_p = 0, mp_p = 0;
  bit         e_v;
  int         e_id;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic int sgi_of(int s);
    return (s * 5 + 3) % 8;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply();
    for (int i = 0; i < NS; i++) begin
      pend_i[i] = m_pend[i];
      prio_i[i*8 +: 8] = m_prio[i];
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < NS; i++) m_pend[i] = 0;
    apply();
  endtask

  task automatic model_sel();
    int bp;
    bit ok;
    e_v = 0; e_id = 0; bp = 256;
    for (int i = 0; i < NS; i++) begin
      ok = m_pend[i] && (m_prio[i] < m_mask)
           && !(mc_v && mc_id == i) && !(mp_v && mp_id == i)
           && !(mc_v && mp_v) && (!mc_v || m_prio[i] < mc_p);
      if (ok && int'(m_prio[i]) < bp) begin
        bp = int'(m_prio[i]); e_id = i; e_v = 1;
      end
    end
  endtask

  task automatic settle_irq(string tag);
    @(negedge clk); @(negedge clk);
    model_sel();
    chk(irq_o == (m_en && e_v), tag, irq_o, m_en && e_v);
  endtask

  task automatic reg_write(int addr, logic [31:0] data);
    reg_wr_i = 1; reg_addr_i = 2'(addr); reg_wdata_i = data;
    @(negedge clk);
    reg_wr_i = 0;
  endtask

  task automatic reg_read(int addr, output logic [31:0] data);
    reg_rd_i = 1; reg_addr_i = 2'(addr);
    #1 data = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 0;
  endtask

  task automatic do_ack(string tag);
    logic [31:0] got, exp;
    bit grant, old_irq;
    model_sel();
    grant = m_en && e_v;
    old_irq = grant;
    exp = grant ? {19'd0, (e_id < NG) ? 3'(sgi_of(e_id)) : 3'd0, 10'(e_id)} : 32'd1023;
    reg_rd_i = 1; reg_addr_i = 2'd2;
    #1 got = reg_rdata_o;
    chk(got == exp, grant ? ((e_id < NG) ? {tag, " R5 sgi claim"} : {tag, " R4 claim"}) : {tag, " R6 spurious"},
        got, exp);
    @(negedge clk);
    reg_rd_i = 0;
    chk(act_o == grant, grant ? "R4 act strobe" : "R6 no act strobe", act_o, grant);
    if (grant) begin
      chk(act_id_o == 10'(e_id), "R4 act id", act_id_o, e_id);
      chk(act_id_o < NS, "R11 id range", act_id_o, NS - 1);
    end
    chk(irq_o == old_irq, "R10 irq registered", irq_o, old_irq);
    if (grant) begin
      mp_v = mc_v; mp_id = mc_id; mp_p = mc_p;
      mc_v = 1; mc_id = e_id; mc_p = m_prio[e_id];
      m_pend[e_id] = 0;
      apply();
    end
    @(negedge clk);
    model_sel();
    chk(irq_o == (m_en && e_v), "R10 irq after claim", irq_o, m_en && e_v);
  endtask

  task automatic do_eoi(int id);
    bit hit;
    int hid;
    reg_write(3, 32'(id));
    hit = 0; hid = id;
    if (mc_v && mc_id == id) begin
      hit = 1; mc_v = mp_v; mc_id = mp_id; mc_p = mp_p; mp_v = 0;
    end else if (mp_v && mp_id == id) begin
      hit = 1; mp_v = 0;
    end
    chk(deact_o == hit, hit ? "R7 retire strobe" : "R8 ignored completion", deact_o, hit);
    if (hit) chk(deact_id_o == 10'(hid), "R7 retire id", deact_id_o, hid);
    settle_irq(hit ? "R7 irq after retire" : "R8 state unchanged");
  endtask

  initial begin
    logic [31:0] rd;
    logic [7:0] plist [5];
    logic [7:0] mlist [5];
    plist = '{8'h00, 8'h7F, 8'hEF, 8'hF0, 8'hFF};
    mlist = '{8'hF0, 8'h80, 8'hFF, 8'h00, 8'hE0};
    for (int s = 0; s < NG; s++) sgi_cpu_i[s*CW +: CW] = 3'(sgi_of(s));
    for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_prio[i] = 8'hA0; end
    apply();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(irq_o == 0, "R10 reset irq", irq_o, 0);
    reg_read(0, rd); chk(rd == 0, "R1 reset control", rd, 0);
    reg_read(1, rd); chk(rd == 0, "R2 reset threshold", rd, 0);

    // Disabled interface: no signalling, spurious claim
    m_mask = 8'hF0; reg_write(1, 32'hF0);
    m_pend[20] = 1; m_prio[20] = 8'h10; apply();
    settle_irq("R1 disabled irq low");
    do_ack("R1 disabled");
    m_en = 1; reg_write(0, 32'h1);
    reg_read(0, rd); chk(rd == 1, "R1 control readback", rd, 1);
    reg_read(1, rd); chk(rd == 32'hF0, "R2 threshold readback", rd, 32'hF0);
    settle_irq("R1 enabled irq");
    do_ack("R1 enabled");
    do_eoi(20);
    clear_all();

    // Single-source sweep over every source and boundary priorities
    for (int i = 0; i < NS; i++) begin
      for (int k = 0; k < 5; k++) begin
        clear_all();
        m_pend[i] = 1; m_prio[i] = plist[k]; apply();
        settle_irq("R2 single source irq");
        do_ack("R2 single source");
        if (mc_v) do_eoi(mc_id);
      end
    end

    // Ties: lowest number wins; equal priority cannot preempt
    for (int a = 0; a < NS; a++) begin
      int b;
      b = (a * 7 + 5) % NS;
      if (b != a) begin
        clear_all();
        m_pend[a] = 1; m_pend[b] = 1; m_prio[a] = 8'h40; m_prio[b] = 8'h40; apply();
        settle_irq("R3 tie irq");
        do_ack("R3 tie");
        settle_irq("R9 equal priority blocked");
        do_eoi(mc_id);
        do_ack("R3 tie second");
        do_eoi(mc_id);
      end
    end

    // Directed preemption with out-of-order completion
    clear_all();
    m_pend[5] = 1; m_prio[5] = 8'h40; apply();
    settle_irq("R9 first");
    do_ack("R9 first");
    m_pend[9] = 1; m_prio[9] = 8'h40; apply();
    settle_irq("R9 equal blocked");
    m_prio[9] = 8'h30; apply();
    settle_irq("R9 better preempts");
    do_ack("R9 preempt");
    m_pend[3] = 1; m_prio[3] = 8'h10; apply();
    settle_irq("R9 two active blocks all");
    do_ack("R9 full");
    do_eoi(1023);
    do_eoi(1020);
    do_eoi(5);
    settle_irq("R9 after out-of-order retire");
    do_ack("R9 after retire");
    do_eoi(mc_id);
    do_eoi(mc_id);
    clear_all();

    // Pseudo-random mixture
    for (int it = 0; it < 600; it++) begin
      logic [31:0] r;
      r = rnd();
      case (r % 8)
        0, 1, 2: begin
          logic [31:0] pm;
          pm = rnd();
          for (int i = 0; i < NS; i++) begin
            logic [31:0] v;
            v = rnd();
            m_pend[i] = pm[i] & v[12];
            m_prio[i] = v[8] ? v[7:0] : {v[2:0], 5'h0};
          end
          apply();
          settle_irq("R3 random pattern irq");
        end
        3, 4: do_ack("R3 random");
        5: do_eoi(mc_v ? mc_id : 1020);
        6: do_eoi(mp_v ? mp_id : int'(r[17:8]));
        default: begin
          m_mask = mlist[(r >> 8) % 5];
          reg_write(1, 32'(m_mask));
          settle_irq("R2 threshold change");
        end
      endcase
    end

    // Disable with work pending
    clear_all();
    while (mc_v) do_eoi(mc_id);
    m_mask = 8'hF0; reg_write(1, 32'hF0);
    m_pend[31] = 1; m_prio[31] = 8'h20; apply();
    settle_irq("R1 pending before disable");
    m_en = 0; reg_write(0, 32'h0);
    settle_irq("R1 disable drops irq");
    do_ack("R1 disabled again");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule